// File: doc/BRIEF.md
# Two-Way Cache Level Message Interface

This block connects a first-level cache controller to a second-level cache controller. Traffic moves in two directions. Toward the second level it carries processor requests and intervention replies. Toward the first level it carries interventions and processor responses. Each of the four message classes has its own FIFO. Requests and replies therefore never share storage, and a reply can never be stuck behind a request in the same queue.

Every producer pushes through a valid/ready port, and every consumer pops through a valid/ready port. A transfer happens on a rising clock edge where valid and ready are both high.

- Back-pressure on a push: ready is low exactly when that queue is full. A refused message stays with its producer.
- Gating on a pop: pop-side valid is high only when the queue holds a message and its drain rule allows removal. A drain rule checks for room in the queue that the head message could need to fill. That check uses the occupancy at the start of the cycle, before anything is removed.

With these rules the queue dependence graph has no cycle, so the two controllers cannot deadlock on queue space.

Top module: `cache_msg_link`

## Requirements
- R1: Each queue delivers messages on its pop port in the order they were accepted on its push port. A message is a vector of type (2 bits, top), then address (ADDR_W bits), then tag (TAG_W bits, bottom). Queue index and type code match: 0 = processor request, 1 = intervention reply, 2 = intervention, 3 = processor response. A head message is presented whenever the queue is non-empty.
- R2: The two queues toward the second level hold OUTST+1 entries, and the two queues toward the first level hold OUTST entries. Push ready is low exactly when a queue is full, and no stored entry is ever overwritten.
- R3: `l2_req_valid` is high only when the processor request queue is non-empty and the processor response queue is below OUTST entries.
- R4: `l1_rsp_valid` is high whenever the processor response queue is non-empty, with no other condition.
- R5: `l1_intv_valid` is high only when the intervention queue is non-empty and the intervention reply queue is below OUTST+1 entries.
- R6: `bus_rep_valid` is high only when the intervention reply queue is non-empty and `bus_grant` is high.
- R7: Each count output equals the queue's occupancy. An accepted push adds one, an accepted pop removes one, and both in one cycle leave the count unchanged.
- R8: Bit q of `type_err` is high in the cycle after queue q accepted a push whose type field is not q, and low otherwise. The mismatched message is still stored.
- R9: The space checks use start-of-cycle occupancy. A pop of the full dependent queue in the same cycle does not open the gate. Beyond the two space checks, the gated pops do not affect each other, so both may complete in the same cycle.
- R10: After reset all queues are empty, every count is 0, all pop valids and `type_err` are low, and all push readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Processor request push valid |
| up_req_ready | output | 1 | Processor request queue not full |
| up_req_msg | input | MSG_W | Processor request message |
| up_rep_valid | input | 1 | Intervention reply push valid |
| up_rep_ready | output | 1 | Intervention reply queue not full |
| up_rep_msg | input | MSG_W | Intervention reply message |
| dn_intv_valid | input | 1 | Intervention push valid |
| dn_intv_ready | output | 1 | Intervention queue not full |
| dn_intv_msg | input | MSG_W | Intervention message |
| dn_rsp_valid | input | 1 | Processor response push valid |
| dn_rsp_ready | output | 1 | Processor response queue not full |
| dn_rsp_msg | input | MSG_W | Processor response message |
| l2_req_valid | output | 1 | Gated head valid of processor request queue |
| l2_req_ready | input | 1 | Second level takes the request head |
| l2_req_msg | output | MSG_W | Processor request head |
| bus_grant | input | 1 | Bus granted for reply transfer |
| bus_rep_valid | output | 1 | Gated head valid of intervention reply queue |
| bus_rep_ready | input | 1 | Bus takes the reply head |
| bus_rep_msg | output | MSG_W | Intervention reply head |
| l1_intv_valid | output | 1 | Gated head valid of intervention queue |
| l1_intv_ready | input | 1 | First level takes the intervention head |
| l1_intv_msg | output | MSG_W | Intervention head |
| l1_rsp_valid | output | 1 | Head valid of processor response queue |
| l1_rsp_ready | input | 1 | First level takes the response head |
| l1_rsp_msg | output | MSG_W | Processor response head |
| cnt_up_req | output | CW | Processor request queue occupancy |
| cnt_up_rep | output | CW | Intervention reply queue occupancy |
| cnt_dn_intv | output | CW | Intervention queue occupancy |
| cnt_dn_rsp | output | CW | Processor response queue occupancy |
| type_err | output | 4 | Per-queue type mismatch flag, one cycle after the push |

## Verification
Two events can fall in the same cycle: a gated pop of the request or intervention queue, and a push or pop on the queue it depends on. The sharpest case is a pop of a full processor response queue while a request waits at the head. The bench creates it in a stress phase that fills the response queue and then drains it slowly with the request consumer always ready, and checks that the request stays gated in that cycle. A behavioural queue model predicts every valid, ready, head and count on each cycle. The bench also confirms that both gated pops completed together at least once.

// File: rtl/cml_pkg.sv
package cml_pkg;
  typedef enum logic [1:0] {
    MK_PREQ = 2'd0,
    MK_IREP = 2'd1,
    MK_INTV = 2'd2,
    MK_PRSP = 2'd3
  } msg_kind_e;

  localparam int NQ = 4;

  function automatic int queue_depth(input int q, input int outst);
    return (q < 2) ? outst + 1 : outst;
  endfunction
endpackage

// File: rtl/cml_fifo.sv
module cml_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 8,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [W-1:0]  push_data,
  input  logic          pop_allow,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign push_ready = (occ != CW'(DEPTH));
  assign pop_valid  = (occ != '0) && pop_allow;
  assign pop_data   = store[rd_ptr];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;
  assign count      = occ;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH) && !pop_ready) |=> occ == CW'(DEPTH));
  assert_count_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> occ == $past(occ) + CW'(1));
  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> occ == $past(occ) - CW'(1));
endmodule

// File: rtl/cml_kind_check.sv
module cml_kind_check #(
  parameter logic [1:0] EXPECT = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [1:0] kind,
  output logic       err
);
  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= accept && (kind != EXPECT);
  end

  assert_flag_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind != EXPECT) |=> err);
  assert_flag_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !err);
endmodule

// File: rtl/cml_gate.sv
module cml_gate (
  input  logic [3:0] has_room,
  input  logic       grant,
  output logic [3:0] allow
);
  always_comb begin
    allow[cml_pkg::MK_PREQ] = has_room[cml_pkg::MK_PRSP];
    allow[cml_pkg::MK_IREP] = grant;
    allow[cml_pkg::MK_INTV] = has_room[cml_pkg::MK_IREP];
    allow[cml_pkg::MK_PRSP] = 1'b1;
  end
endmodule

// File: rtl/cache_msg_link.sv
module cache_msg_link #(
  parameter int OUTST  = 2,
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 4,
  localparam int MSG_W = 2 + ADDR_W + TAG_W,
  localparam int CW    = $clog2(OUTST + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req_valid,
  output logic             up_req_ready,
  input  logic [MSG_W-1:0] up_req_msg,
  input  logic             up_rep_valid,
  output logic             up_rep_ready,
  input  logic [MSG_W-1:0] up_rep_msg,
  input  logic             dn_intv_valid,
  output logic             dn_intv_ready,
  input  logic [MSG_W-1:0] dn_intv_msg,
  input  logic             dn_rsp_valid,
  output logic             dn_rsp_ready,
  input  logic [MSG_W-1:0] dn_rsp_msg,
  output logic             l2_req_valid,
  input  logic             l2_req_ready,
  output logic [MSG_W-1:0] l2_req_msg,
  input  logic             bus_grant,
  output logic             bus_rep_valid,
  input  logic             bus_rep_ready,
  output logic [MSG_W-1:0] bus_rep_msg,
  output logic             l1_intv_valid,
  input  logic             l1_intv_ready,
  output logic [MSG_W-1:0] l1_intv_msg,
  output logic             l1_rsp_valid,
  input  logic             l1_rsp_ready,
  output logic [MSG_W-1:0] l1_rsp_msg,
  output logic [CW-1:0]    cnt_up_req,
  output logic [CW-1:0]    cnt_up_rep,
  output logic [CW-1:0]    cnt_dn_intv,
  output logic [CW-1:0]    cnt_dn_rsp,
  output logic [3:0]       type_err
);
  import cml_pkg::*;

  logic [3:0]       in_v, in_r, out_v, out_r, allow;
  logic [MSG_W-1:0] in_d  [NQ];
  logic [MSG_W-1:0] out_d [NQ];
  logic [CW-1:0]    occ   [NQ];

  assign in_v = {dn_rsp_valid, dn_intv_valid, up_rep_valid, up_req_valid};
  assign in_d[MK_PREQ] = up_req_msg;
  assign in_d[MK_IREP] = up_rep_msg;
  assign in_d[MK_INTV] = dn_intv_msg;
  assign in_d[MK_PRSP] = dn_rsp_msg;
  assign {dn_rsp_ready, dn_intv_ready, up_rep_ready, up_req_ready} = in_r;

  assign out_r = {l1_rsp_ready, l1_intv_ready, bus_rep_ready, l2_req_ready};
  assign {l1_rsp_valid, l1_intv_valid, bus_rep_valid, l2_req_valid} = out_v;
  assign l2_req_msg  = out_d[MK_PREQ];
  assign bus_rep_msg = out_d[MK_IREP];
  assign l1_intv_msg = out_d[MK_INTV];
  assign l1_rsp_msg  = out_d[MK_PRSP];

  assign cnt_up_req  = occ[MK_PREQ];
  assign cnt_up_rep  = occ[MK_IREP];
  assign cnt_dn_intv = occ[MK_INTV];
  assign cnt_dn_rsp  = occ[MK_PRSP];

  cml_gate u_gate (
    .has_room (in_r),
    .grant    (bus_grant),
    .allow    (allow)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    localparam int QD = queue_depth(q, OUTST);

    cml_fifo #(.DEPTH(QD), .W(MSG_W), .CW(CW)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (in_v[q]),
      .push_ready (in_r[q]),
      .push_data  (in_d[q]),
      .pop_allow  (allow[q]),
      .pop_valid  (out_v[q]),
      .pop_ready  (out_r[q]),
      .pop_data   (out_d[q]),
      .count      (occ[q])
    );

    cml_kind_check #(.EXPECT(2'(q))) u_kind (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (in_v[q] && in_r[q]),
      .kind   (in_d[q][MSG_W-1 -: 2]),
      .err    (type_err[q])
    );
  end

  assert_req_needs_rsp_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_req_valid && l2_req_ready) |-> cnt_dn_rsp < CW'(OUTST));
  assert_rsp_ungated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dn_rsp != '0) |-> l1_rsp_valid);
  assert_intv_needs_rep_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_intv_valid && l1_intv_ready) |-> cnt_up_rep < CW'(OUTST + 1));
  assert_rep_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rep_valid && bus_rep_ready) |-> bus_grant);
  assert_start_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dn_rsp == CW'(OUTST) && l1_rsp_ready) |-> !l2_req_valid);
endmodule

// File: tb/test_cache_msg_link.sv
module test_cache_msg_link;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 2;
  localparam int AW = 8;
  localparam int TW = 4;
  localparam int MW = 2 + AW + TW;
  localparam int CW = $clog2(P + 2);
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic [3:0] iv = '0, orr = '0;
  logic [3:0] ir, ov, terr;
  logic [MW-1:0] id [4];
  logic [MW-1:0] od [4];
  logic [CW-1:0] cn [4];

  int total = 0, bad = 0, both_cnt = 0, cons_cnt = 0;
  int depth [4];
  logic [MW-1:0] mq [4][$];
  logic [3:0] exp_err = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_msg_link #(.OUTST(P), .ADDR_W(AW), .TAG_W(TW)) i_cache_msg_link (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(iv[0]), .up_req_ready(ir[0]), .up_req_msg(id[0]),
    .up_rep_valid(iv[1]), .up_rep_ready(ir[1]), .up_rep_msg(id[1]),
    .dn_intv_valid(iv[2]), .dn_intv_ready(ir[2]), .dn_intv_msg(id[2]),
    .dn_rsp_valid(iv[3]), .dn_rsp_ready(ir[3]), .dn_rsp_msg(id[3]),
    .l2_req_valid(ov[0]), .l2_req_ready(orr[0]), .l2_req_msg(od[0]),
    .bus_grant(grant),
    .bus_rep_valid(ov[1]), .bus_rep_ready(orr[1]), .bus_rep_msg(od[1]),
    .l1_intv_valid(ov[2]), .l1_intv_ready(orr[2]), .l1_intv_msg(od[2]),
    .l1_rsp_valid(ov[3]), .l1_rsp_ready(orr[3]), .l1_rsp_msg(od[3]),
    .cnt_up_req(cn[0]), .cnt_up_rep(cn[1]), .cnt_dn_intv(cn[2]), .cnt_dn_rsp(cn[3]),
    .type_err(terr)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int q = 0; q < 4; q++) begin
      depth[q] = (q < 2) ? P + 1 : P;
      id[q] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: state right after reset
    for (int q = 0; q < 4; q++) begin
      chk("R10", "count after reset", 32'(cn[q]), 0);
      chk("R10", "pop valid after reset", 32'(ov[q]), 0);
      chk("R10", "push ready after reset", 32'(ir[q]), 1);
    end
    chk("R10", "type_err after reset", 32'(terr), 0);

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      int phase;
      int pp, rp;
      logic [3:0] allow, ev, er, pushf, popf, nerr;
      @(negedge clk);
      phase = (cyc / 250) % 4;
      case (phase)
        0: begin pp = 70; rp = 15; end
        1: begin pp = 20; rp = 90; end
        default: begin pp = 55; rp = 55; end
      endcase
      for (int q = 0; q < 4; q++) begin
        logic [1:0] k;
        k = pct(8) ? 2'($urandom) : 2'(q);
        iv[q]  = pct(pp);
        id[q]  = {k, AW'($urandom), TW'($urandom)};
        orr[q] = pct(rp);
      end
      grant = pct(60);
      if (phase == 3) begin
        iv[3] = pct(85); orr[3] = pct(30);
        iv[0] = pct(85); orr[0] = 1'b1;
      end
      #1;
      for (int q = 0; q < 4; q++) er[q] = mq[q].size() < depth[q];
      allow[0] = mq[3].size() < depth[3];
      allow[1] = grant;
      allow[2] = mq[1].size() < depth[1];
      allow[3] = 1'b1;
      for (int q = 0; q < 4; q++) ev[q] = (mq[q].size() > 0) && allow[q];

      chk("R2", "push ready", 32'(ir), 32'(er));
      chk("R3", "request pop valid", 32'(ov[0]), 32'(ev[0]));
      chk("R6", "reply pop valid", 32'(ov[1]), 32'(ev[1]));
      chk("R5", "intervention pop valid", 32'(ov[2]), 32'(ev[2]));
      chk("R4", "response pop valid", 32'(ov[3]), 32'(ev[3]));
      chk("R8", "type_err", 32'(terr), 32'(exp_err));
      for (int q = 0; q < 4; q++) begin
        chk("R7", "count", 32'(cn[q]), 32'(mq[q].size()));
        if (mq[q].size() > 0) chk("R1", "head message", 32'(od[q]), 32'(mq[q][0]));
      end

      for (int q = 0; q < 4; q++) begin
        pushf[q] = iv[q] && er[q];
        popf[q]  = ev[q] && orr[q];
        nerr[q]  = pushf[q] && (id[q][MW-1 -: 2] != 2'(q));
      end
      // R9: both gated pops together, and the conservative start-of-cycle case
      if (popf[0] && popf[2]) both_cnt++;
      if (mq[3].size() == depth[3] && popf[3] && orr[0] && mq[0].size() > 0) cons_cnt++;
      for (int q = 0; q < 4; q++) begin
        if (popf[q]) void'(mq[q].pop_front());
        if (pushf[q]) mq[q].push_back(id[q]);
      end
      exp_err = nerr;
    end
    chk("R9", "both gated pops in one cycle seen", 32'(both_cnt > 0), 1);
    chk("R9", "full response queue popped with request waiting seen", 32'(cons_cnt > 0), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule